// File: doc/BRIEF.md
# Rate-Limited Variable Setpoint Bistable

This block watches a live power value and keeps a moving trip threshold close above it. While power changes slowly, the threshold rides a fixed margin above the measured value. When an external rate detector reports a fast rise, the threshold stops following. It takes one fixed step up from where it was and then stays there. Power that keeps climbing then crosses a level that no longer runs away from it. A configurable floor and ceiling bound the threshold. A pretrip threshold always sits a fixed offset below the trip threshold and gives an early warning.

Two latching outputs, trip and pretrip, are set when power crosses their threshold during a fast rise, or when power reaches the ceiling. Each output is released only after power falls below its threshold by at least the hysteresis amount. All values are unsigned counts, with `PCT` counts per percent of full power. The rate flag, floor, ceiling and hysteresis come from outside the block.

Top module: `vsb_rate_bistable`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `trip_sp` equals `sp_floor`, `pre_sp` equals `sp_floor` minus the pretrip offset (0 if that would be negative), and `trip` and `pretrip` are 0.
- R2: At an edge where `fast_rise` is 0, the new `trip_sp` is `power + RISE_PCT*PCT`, unless R5 or R6 applies.
- R3: At an edge where `fast_rise` is 1 and was 0 (or reset was active) at the previous edge, the new `trip_sp` is the old `trip_sp + STEP_PCT*PCT`, unless R5 or R6 applies.
- R4: At an edge where `fast_rise` is 1 and was also 1 at the previous non-reset edge, `trip_sp` and `pre_sp` keep their values.
- R5: A candidate from R2 or R3 that is greater than or equal to `sp_ceil` is replaced by `sp_ceil`. The sum is formed one bit wider than `W`, so it never wraps.
- R6: A candidate that is not clamped by R5 and is less than or equal to `sp_floor` is replaced by `sp_floor`.
- R7: `pre_sp` is updated at the same edge as `trip_sp` and equals it minus `PRE_PCT*PCT`, saturating at 0.
- R8: At an edge where `fast_rise` is 1 and `power` is at least the current `trip_sp`, `trip` is 1 after that edge.
- R9: At an edge where `power` is at least `sp_ceil`, `trip` and `pretrip` are 1 after that edge, whatever the value of `fast_rise`.
- R10: When no set condition holds, `trip` goes to 0 only if `power + hyst` is less than the current `trip_sp`. Otherwise it keeps its value.
- R11: `pretrip` follows the rules of R8 and R10, with `pre_sp` in place of `trip_sp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| power | input | W | Live power value, PCT counts per percent |
| fast_rise | input | 1 | Externally detected fast-rise (max rate) flag |
| sp_floor | input | W | Lowest allowed trip setpoint |
| sp_ceil | input | W | Highest allowed trip setpoint, also the direct trip level |
| hyst | input | W | Release margin for trip and pretrip |
| trip_sp | output | W | Registered trip setpoint |
| pre_sp | output | W | Registered pretrip setpoint |
| trip | output | 1 | Registered trip output |
| pretrip | output | 1 | Registered pretrip output |

## Verification
The bench builds the block with `W=10` and `PCT=4`. The margins become 60, 44 and 24 counts, and full scale is about 256 percent. This makes three cases reachable with small stimulus. Power near the top of the range makes the follow candidate exceed the `W`-bit range, which exercises the wide compare in R5. A small floor drives the pretrip subtraction into saturation under R7. A 400-count ceiling can be crossed both by ramps and by a random walk. Directed ramps hold the rate flag high across a threshold to exercise the frozen step and the hysteresis release. A long random walk with random rate flag runs then compares every output against a behavioural model on every cycle.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

   // Controller modes; the first five describe the setpoint path, the last
   // two are the latch states of each bistable.
   typedef enum logic [2:0] {
      M_FOLLOW  = 3'd0,
      M_FLOOR   = 3'd1,
      M_MAXRATE = 3'd2,
      M_UPDATE  = 3'd3,
      M_CEILING = 3'd4,
      M_TRIP    = 3'd5,
      M_UNTRIP  = 3'd6
   } vsb_mode_e;

   // Setpoint multiplexer select codes.
   typedef enum logic [1:0] {
      SEL_STEP  = 2'b00,
      SEL_RISE  = 2'b01,
      SEL_FLOOR = 2'b10,
      SEL_CEIL  = 2'b11
   } vsb_sel_e;

endpackage

// File: rtl/vsb_sp_ctrl.sv
module vsb_sp_ctrl
   import vsb_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      fast_rise,
   input  logic      step_hi,
   input  logic      step_lo,
   input  logic      rise_hi,
   input  logic      rise_lo,
   output logic      ld,
   output vsb_sel_e  sel,
   output vsb_mode_e mode
);

   logic      fr_q;
   logic      fr_edge;
   logic      cand_hi;
   logic      cand_lo;
   vsb_mode_e mode_nxt;

   assign fr_edge = fast_rise & ~fr_q;
   assign cand_hi = fr_edge ? step_hi : rise_hi;
   assign cand_lo = fr_edge ? step_lo : rise_lo;

   always_comb begin
      ld       = 1'b1;
      sel      = SEL_RISE;
      mode_nxt = M_FOLLOW;
      if (fast_rise && !fr_edge) begin
         ld       = 1'b0;
         sel      = SEL_STEP;
         mode_nxt = M_UPDATE;
      end else if (cand_hi) begin
         sel      = SEL_CEIL;
         mode_nxt = M_CEILING;
      end else if (cand_lo) begin
         sel      = SEL_FLOOR;
         mode_nxt = M_FLOOR;
      end else if (fr_edge) begin
         sel      = SEL_STEP;
         mode_nxt = M_MAXRATE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fr_q <= 1'b0;
         mode <= M_FOLLOW;
      end else begin
         fr_q <= fast_rise;
         mode <= mode_nxt;
      end
   end

endmodule

// File: rtl/vsb_setpoint_path.sv
module vsb_setpoint_path
   import vsb_pkg::*;
#(
   parameter int W      = 12,
   parameter int RISE_C = 150,
   parameter int STEP_C = 110,
   parameter int PRE_C  = 60
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] power,
   input  logic [W-1:0] sp_floor,
   input  logic [W-1:0] sp_ceil,
   input  logic         ld,
   input  vsb_sel_e     sel,
   output logic         step_hi,
   output logic         step_lo,
   output logic         rise_hi,
   output logic         rise_lo,
   output logic [W-1:0] trip_sp,
   output logic [W-1:0] pre_sp
);

   localparam int WX = W + 1;
   localparam int NC = 2;

   logic [WX-1:0] cand [NC];
   logic [NC-1:0] hi;
   logic [NC-1:0] lo;
   logic [W-1:0]  sp_mux;
   logic [W-1:0]  sp_nxt;

   function automatic logic [W-1:0] pre_of(input logic [W-1:0] sp);
      if (sp > W'(PRE_C)) pre_of = sp - W'(PRE_C);
      else                pre_of = '0;
   endfunction

   assign cand[0] = {1'b0, trip_sp} + WX'(STEP_C);
   assign cand[1] = {1'b0, power}   + WX'(RISE_C);

   for (genvar g = 0; g < NC; g++) begin : g_cmp
      assign hi[g] = cand[g] >= {1'b0, sp_ceil};
      assign lo[g] = cand[g] <= {1'b0, sp_floor};
   end

   assign step_hi = hi[0];
   assign step_lo = lo[0];
   assign rise_hi = hi[1];
   assign rise_lo = lo[1];

   always_comb begin
      case (sel)
         SEL_STEP:  sp_mux = cand[0][W-1:0];
         SEL_RISE:  sp_mux = cand[1][W-1:0];
         SEL_FLOOR: sp_mux = sp_floor;
         default:   sp_mux = sp_ceil;
      endcase
   end

   assign sp_nxt = ld ? sp_mux : trip_sp;

   always_ff @(posedge clk) begin
      if (rst) begin
         trip_sp <= sp_floor;
         pre_sp  <= pre_of(sp_floor);
      end else begin
         trip_sp <= sp_nxt;
         pre_sp  <= pre_of(sp_nxt);
      end
   end

endmodule

// File: rtl/vsb_bistable.sv
module vsb_bistable
   import vsb_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] power,
   input  logic [W-1:0] thr,
   input  logic         arm,
   input  logic [W-1:0] ceil_lvl,
   input  logic [W-1:0] hyst,
   output logic         q
);

   vsb_mode_e st;
   vsb_mode_e st_nxt;
   logic      set_c;
   logic      clr_c;

   assign set_c = (arm && (power >= thr)) || (power >= ceil_lvl);
   assign clr_c = ({1'b0, power} + {1'b0, hyst}) < {1'b0, thr};

   always_comb begin
      st_nxt = st;
      if (set_c)      st_nxt = M_TRIP;
      else if (clr_c) st_nxt = M_UNTRIP;
   end

   always_ff @(posedge clk) begin
      if (rst) st <= M_UNTRIP;
      else     st <= st_nxt;
   end

   assign q = (st == M_TRIP);

endmodule

// File: rtl/vsb_rate_bistable.sv
module vsb_rate_bistable
   import vsb_pkg::*;
#(
   parameter int W        = 12,
   parameter int PCT      = 10,
   parameter int RISE_PCT = 15,
   parameter int STEP_PCT = 11,
   parameter int PRE_PCT  = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] power,
   input  logic         fast_rise,
   input  logic [W-1:0] sp_floor,
   input  logic [W-1:0] sp_ceil,
   input  logic [W-1:0] hyst,
   output logic [W-1:0] trip_sp,
   output logic [W-1:0] pre_sp,
   output logic         trip,
   output logic         pretrip
);

   localparam int RISE_C = RISE_PCT * PCT;
   localparam int STEP_C = STEP_PCT * PCT;
   localparam int PRE_C  = PRE_PCT * PCT;
   localparam int NB     = 2;

   if (W < 4) begin : g_bad_w
      $error("vsb_rate_bistable: W must be at least 4");
   end
   if (PCT < 1) begin : g_bad_pct
      $error("vsb_rate_bistable: PCT must be positive");
   end
   if (RISE_C >= (1 << W) || STEP_C >= (1 << W) || PRE_C >= (1 << W)) begin : g_bad_ofs
      $error("vsb_rate_bistable: an offset does not fit in W bits");
   end

   logic      ld;
   vsb_sel_e  sel;
   vsb_mode_e sp_mode;
   logic      step_hi;
   logic      step_lo;
   logic      rise_hi;
   logic      rise_lo;

   vsb_sp_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .fast_rise (fast_rise),
      .step_hi   (step_hi),
      .step_lo   (step_lo),
      .rise_hi   (rise_hi),
      .rise_lo   (rise_lo),
      .ld        (ld),
      .sel       (sel),
      .mode      (sp_mode)
   );

   vsb_setpoint_path #(
      .W      (W),
      .RISE_C (RISE_C),
      .STEP_C (STEP_C),
      .PRE_C  (PRE_C)
   ) u_path (
      .clk      (clk),
      .rst      (rst),
      .power    (power),
      .sp_floor (sp_floor),
      .sp_ceil  (sp_ceil),
      .ld       (ld),
      .sel      (sel),
      .step_hi  (step_hi),
      .step_lo  (step_lo),
      .rise_hi  (rise_hi),
      .rise_lo  (rise_lo),
      .trip_sp  (trip_sp),
      .pre_sp   (pre_sp)
   );

   logic [W-1:0] thr_v [NB];
   logic [NB-1:0] q_v;

   assign thr_v[0] = trip_sp;
   assign thr_v[1] = pre_sp;

   for (genvar b = 0; b < NB; b++) begin : g_bst
      vsb_bistable #(.W(W)) u_bst (
         .clk      (clk),
         .rst      (rst),
         .power    (power),
         .thr      (thr_v[b]),
         .arm      (fast_rise),
         .ceil_lvl (sp_ceil),
         .hyst     (hyst),
         .q        (q_v[b])
      );
   end

   assign trip    = q_v[0];
   assign pretrip = q_v[1];

endmodule

// File: rtl/vsb_rate_bistable_chk.sv
module vsb_rate_bistable_chk
   import vsb_pkg::*;
#(
   parameter int W     = 12,
   parameter int PRE_C = 60
) (
   input logic         clk,
   input logic         rst,
   input logic [W-1:0] power,
   input logic         fast_rise,
   input logic [W-1:0] sp_floor,
   input logic [W-1:0] sp_ceil,
   input logic [W-1:0] hyst,
   input logic [W-1:0] trip_sp,
   input logic [W-1:0] pre_sp,
   input logic         trip,
   input logic         pretrip,
   input vsb_mode_e    sp_mode
);

   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!trip && !pretrip && trip_sp == $past(sp_floor)));

   a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
      (fast_rise && $past(fast_rise) && !$past(rst)) |=> (trip_sp == $past(trip_sp)));

   a_r5_ceiling_mode: assert property (@(posedge clk) disable iff (rst)
      (sp_mode == M_CEILING) |-> (trip_sp == $past(sp_ceil)));

   a_r6_floor_mode: assert property (@(posedge clk) disable iff (rst)
      (sp_mode == M_FLOOR) |-> (trip_sp == $past(sp_floor)));

   a_r7_pre_offset: assert property (@(posedge clk) disable iff (rst)
      (trip_sp > W'(PRE_C)) ? (pre_sp == trip_sp - W'(PRE_C)) : (pre_sp == '0));

   a_r8_fast_cross: assert property (@(posedge clk) disable iff (rst)
      (fast_rise && power >= trip_sp) |=> trip);

   a_r9_ceiling_trip: assert property (@(posedge clk) disable iff (rst)
      (power >= sp_ceil) |=> (trip && pretrip));

   a_r10_release_margin: assert property (@(posedge clk) disable iff (rst)
      $fell(trip) |-> (({1'b0, $past(power)} + {1'b0, $past(hyst)}) < {1'b0, $past(trip_sp)}));

   a_r11_pre_cross: assert property (@(posedge clk) disable iff (rst)
      (fast_rise && power >= pre_sp) |=> pretrip);

endmodule

bind vsb_rate_bistable vsb_rate_bistable_chk #(.W(W), .PRE_C(PRE_C)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .power     (power),
   .fast_rise (fast_rise),
   .sp_floor  (sp_floor),
   .sp_ceil   (sp_ceil),
   .hyst      (hyst),
   .trip_sp   (trip_sp),
   .pre_sp    (pre_sp),
   .trip      (trip),
   .pretrip   (pretrip),
   .sp_mode   (sp_mode)
);

// File: tb/sim_vsb_rate_bistable.sv
module sim_vsb_rate_bistable;

   localparam int W    = 10;
   localparam int PCT  = 4;
   localparam int RISE = 15 * PCT;
   localparam int STEP = 11 * PCT;
   localparam int PRE  = 6 * PCT;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] power = '0;
   logic         fast_rise = 1'b0;
   logic [W-1:0] sp_floor = W'(80);
   logic [W-1:0] sp_ceil = W'(400);
   logic [W-1:0] hyst = W'(8);
   logic [W-1:0] trip_sp;
   logic [W-1:0] pre_sp;
   logic         trip;
   logic         pretrip;

   int    vectors = 0;
   int    misses  = 0;
   bit    done    = 0;
   string req     = "R1";

   int m_sp, m_pre, m_trip, m_pt, m_frq;
   bit m_valid = 0;

   always #10 clk = ~clk;

   vsb_rate_bistable #(.W(W), .PCT(PCT)) u0 (
      .clk(clk), .rst(rst), .power(power), .fast_rise(fast_rise),
      .sp_floor(sp_floor), .sp_ceil(sp_ceil), .hyst(hyst),
      .trip_sp(trip_sp), .pre_sp(pre_sp), .trip(trip), .pretrip(pretrip)
   );

   function automatic int sat_pre(input int sp);
      return (sp > PRE) ? sp - PRE : 0;
   endfunction

   // Behavioural reference, advanced on every rising edge.
   always @(posedge clk) begin
      int p, f, c, fl, ce, h;
      p  = int'(power);
      f  = int'(fast_rise);
      fl = int'(sp_floor);
      ce = int'(sp_ceil);
      h  = int'(hyst);
      if (rst) begin
         m_sp = fl; m_pre = sat_pre(fl); m_trip = 0; m_pt = 0; m_frq = 0;
      end else begin
         if ((f == 1 && p >= m_sp) || p >= ce) m_trip = 1;
         else if (p + h < m_sp)                m_trip = 0;
         if ((f == 1 && p >= m_pre) || p >= ce) m_pt = 1;
         else if (p + h < m_pre)                m_pt = 0;
         if (!(f == 1 && m_frq == 1)) begin
            c = (f == 1) ? m_sp + STEP : p + RISE;
            if (c >= ce)      c = ce;
            else if (c <= fl) c = fl;
            m_sp  = c;
            m_pre = sat_pre(c);
         end
         m_frq = f;
      end
      m_valid = 1;
   end

   task automatic chk(input string what, input int act, input int exp);
      if (act != exp) begin
         misses++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(input int p, input bit f);
      @(negedge clk);
      if (m_valid) begin
         vectors++;
         chk("trip_sp", int'(trip_sp), m_sp);
         chk("pre_sp",  int'(pre_sp),  m_pre);
         chk("trip",    int'(trip),    m_trip);
         chk("pretrip", int'(pretrip), m_pt);
      end
      power     = W'(p);
      fast_rise = f;
   endtask

   task automatic do_reset(input int fl, input int ce, input int h);
      req = "R1";
      @(negedge clk);
      rst = 1'b1;
      sp_floor = W'(fl); sp_ceil = W'(ce); hyst = W'(h);
      step(0, 0);
      step(0, 0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      int p;
      int seed;
      do_reset(80, 400, 8);
      step(0, 0);                       // R1: reset values seen here
      req = "R2";
      for (int i = 0; i < 30; i++) step(100 + 5 * i, 0);
      req = "R6";
      for (int i = 0; i < 6; i++) step(i * 2, 0);
      req = "R5";
      step(360, 0); step(380, 0);
      req = "R9";
      step(400, 0); step(420, 0); step(300, 0); step(200, 0);
      req = "R3";
      step(200, 0); step(200, 0);
      step(200, 1);
      req = "R4";
      for (int i = 1; i < 20; i++) step(200 + 6 * i, 1);
      req = "R8";
      step(310, 1); step(306, 1);
      req = "R11";
      step(290, 1); step(285, 1);
      req = "R10";
      step(300, 1); step(297, 1); step(295, 1); step(290, 1);
      step(290, 0); step(250, 0); step(250, 0);
      req = "R5";
      step(1000, 0); step(1023, 0); step(1023, 1); step(1023, 1); step(0, 0); step(0, 0);
      do_reset(10, 300, 4);
      req = "R7";
      step(0, 0); step(0, 0); step(20, 0); step(0, 1); step(0, 1); step(0, 0);
      do_reset(80, 400, 6);
      req = "R11";
      p = 150;
      seed = 32'h1d2c3b4a;
      for (int i = 0; i < 4000; i++) begin
         seed = seed ^ (seed << 13);
         seed = seed ^ (seed >>> 17);
         seed = seed ^ (seed << 5);
         p = p + ((seed & 63) - 31);
         if (p < 0) p = 0;
         if (p > MAXV) p = MAXV;
         step(p, ((seed >>> 8) & 3) == 0 ? ~fast_rise : fast_rise);
      end
      step(0, 0);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         misses++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

endmodule